// File: doc/BRIEF.md
# FM Read Data Conditioner

This block sits between the raw read-pulse line of a frequency-modulated disk drive and a byte-assembly shift register. Every bit cell on the medium has a clock position followed by a data position, and a flux pulse may be present or absent at either one. Downstream logic needs exactly one read-clock pulse per position, so that it can sample a data level at each one. The block supplies that read clock and the matching data level. All timing is counted in cycles of a single fast sample clock and set by parameters.

The raw pulse passes through a synchronizer and an edge detector. Each detected pulse restarts a retriggerable gap timer. The timer output is the data level. When the timer runs out without a new pulse, a short synthetic marker pulse is made. Raw pulses and markers are merged. Each rising edge of the merged stream is stretched into a read-clock pulse of fixed width. On the cycle after each read-clock rising edge, the block captures the data level and issues a one-cycle strobe. A real pulse therefore reports a 1 and an inserted marker reports a 0. The cell is recovered without any phase-locked loop.

Top module: `fm_read_conditioner`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first cycle after it is released, `rdata_o`, `rck_o` and `bit_valid_o` are 0. A reset that arrives while a pulse is in flight discards that pulse completely, so no strobe follows it.
- R2: Let edge k be the first clock edge that samples a raw pulse high. `rdata_o` rises after edge k+2 and stays high for exactly TIMEOUT_CYC cycles. It is low again after edge k+2+TIMEOUT_CYC.
- R3: A new pulse sampled at most TIMEOUT_CYC edges after the previous one restarts the gap timer. `rdata_o` does not drop, and no marker is inserted for that gap.
- R4: When the gap timer expires, exactly one synthetic read-clock pulse is inserted. Its strobe appears after edge k+TIMEOUT_CYC+5, with `bit_o` = 0. A silence of any length after the last pulse yields exactly one such strobe.
- R5: The read clock rises after edge k+2 and stays high for RCK_CYC cycles. It is low after edge k+2+RCK_CYC.
- R6: `bit_valid_o` is high for exactly one cycle, after edge k+3, for a real pulse, with `bit_o` = 1. Every rising edge of `rck_o` is followed by one strobe on the next cycle.
- R7: For FM streams, the block gives one strobe per clock position and one per data position, always two per cell. Three cases are covered: all ones, all zeros, and a cell with a missing clock pulse. The cell is 80 cycles and the data position is 40 cycles after the clock position.
- R8: Suppose a pulse is sampled exactly TIMEOUT_CYC+1 edges after the previous one, in the same cycle in which the timer expires. The pulse and the marker merge into a single read-clock pulse, and its strobe reports `bit_o` = 1.
- R9: A raw pulse held high for several sample cycles counts once. Its timing is taken from its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_pulse_i | input | 1 | Raw read pulse from the drive, asynchronous, at least one cycle wide |
| rdata_o | output | 1 | Data level: high while the gap timer runs |
| rck_o | output | 1 | Regenerated read clock, RCK_CYC cycles per pulse |
| bit_valid_o | output | 1 | One-cycle strobe, one per read-clock pulse |
| bit_o | output | 1 | Data level captured at the strobe |

## Verification
The hardest situation to reach from the ports is a pulse that lands in the very cycle the gap timer expires. The marker and the real pulse then collide inside the merge logic. The bench uses a free-running cycle counter to place raw pulses at exact edges. It spaces two pulses TIMEOUT_CYC edges apart, which should give no marker. It then spaces two pulses TIMEOUT_CYC+1 edges apart, which should give one merged strobe reporting 1. Full FM cell patterns cover the ordinary clock and data positions.

// File: rtl/fmc_pkg.sv
// Package: shared defaults and width helper for the FM read conditioner.
// Assumes all counts are small positive integers measured in sample cycles.
package fmc_pkg;
    localparam int unsigned FMC_TIMEOUT_DEF = 58;
    localparam int unsigned FMC_MARK_DEF    = 1;
    localparam int unsigned FMC_RCK_DEF     = 8;
    localparam int unsigned FMC_SYNC_DEF    = 2;

    // Bits needed to hold the values 0..maxv.
    function automatic int unsigned cnt_w(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction
endpackage

// File: rtl/fmc_pulse_sync.sv
// Synchronizes the asynchronous raw read pulse into the sample-clock domain.
// Emits a one-cycle event on each rising edge of the pulse.
// Assumes the raw pulse is at least one sample cycle wide.
module fmc_pulse_sync #(
    parameter int unsigned SYNC_STAGES = fmc_pkg::FMC_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic evt_o
);
    // The extra stage past the synchronizer depth is the edge-detect delay.
    logic [SYNC_STAGES:0] chain;

    // Purpose: shift the raw level through the synchronizer and delay stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], raw_i};
        end
    end

    assign evt_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    // R9: an edge event is never two cycles long
    a_r9_single_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);
endmodule

// File: rtl/fmc_gap_timer.sv
// Retriggerable gap timer.
// Each event reloads the timer, and the timer level is the data level.
// When the level falls, a marker pulse MARK_CYC cycles wide is produced.
// Assumes TIMEOUT_CYC is longer than the read-clock width.
module fmc_gap_timer #(
    parameter int unsigned TIMEOUT_CYC = fmc_pkg::FMC_TIMEOUT_DEF,
    parameter int unsigned MARK_CYC    = fmc_pkg::FMC_MARK_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic lvl_o,
    output logic mark_o
);
    localparam int unsigned TW = fmc_pkg::cnt_w(TIMEOUT_CYC);
    localparam int unsigned MW = fmc_pkg::cnt_w(MARK_CYC);
    localparam int unsigned QW = fmc_pkg::cnt_w(TIMEOUT_CYC + 1);

    logic [TW-1:0] gap_cnt;
    logic          lvl_q;
    logic          expire;

    // Purpose: reload on every event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (evt_i) begin
            gap_cnt <= TW'(TIMEOUT_CYC);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign lvl_o = (gap_cnt != '0);

    // Purpose: remember the previous level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_o;
        end
    end

    assign expire = lvl_q & ~lvl_o;

    generate
        if (MARK_CYC <= 1) begin : g_mark_flop
            logic mark_q;
            // Purpose: a one-cycle marker directly from the expiry cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mark_q <= 1'b0;
                end else begin
                    mark_q <= expire;
                end
            end
            assign mark_o = mark_q;
        end else begin : g_mark_cnt
            logic [MW-1:0] mark_cnt;
            // Purpose: hold the marker for MARK_CYC cycles after expiry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mark_cnt <= '0;
                end else if (expire) begin
                    mark_cnt <= MW'(MARK_CYC);
                end else if (mark_cnt != '0) begin
                    mark_cnt <= mark_cnt - 1'b1;
                end
            end
            assign mark_o = (mark_cnt != '0);
        end
    endgenerate

    // Checker state: cycles since the last event, saturating.
    logic [QW-1:0] quiet;
    // Purpose: measure the silence that precedes each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (evt_i) begin
            quiet <= '0;
        end else if (quiet != QW'(TIMEOUT_CYC + 1)) begin
            quiet <= quiet + 1'b1;
        end
    end

    // R2: an event raises the data level on the next cycle
    a_r2_level_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> lvl_o);
    // R3: the level only falls after a full TIMEOUT_CYC of silence
    a_r3_expiry_after_silence: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (quiet == QW'(TIMEOUT_CYC)));
endmodule

// File: rtl/fmc_rck_stretch.sv
// Merges real pulse events with marker pulses.
// Each rising edge of the merged stream becomes a read-clock pulse RCK_CYC cycles wide.
// Assumes consecutive merged edges are normally more than RCK_CYC apart.
// If they are closer, the pulse is extended rather than doubled.
module fmc_rck_stretch #(
    parameter int unsigned RCK_CYC = fmc_pkg::FMC_RCK_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic mark_i,
    output logic rck_o
);
    localparam int unsigned RW = fmc_pkg::cnt_w(RCK_CYC);

    logic          merged;
    logic          merged_q;
    logic          trig;
    logic [RW-1:0] rck_cnt;

    assign merged = evt_i | mark_i;

    // Purpose: delay the merged stream for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged_q <= 1'b0;
        end else begin
            merged_q <= merged;
        end
    end

    assign trig = merged & ~merged_q;

    // Purpose: a width counter loaded on each merged rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rck_cnt <= '0;
        end else if (trig) begin
            rck_cnt <= RW'(RCK_CYC);
        end else if (rck_cnt != '0) begin
            rck_cnt <= rck_cnt - 1'b1;
        end
    end

    assign rck_o = (rck_cnt != '0);

    // Checker state: length of the current high phase, saturating.
    logic          rck_prev;
    logic [RW-1:0] hi_len;
    // Purpose: track how long the read clock has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rck_prev <= 1'b0;
            hi_len   <= '0;
        end else begin
            rck_prev <= rck_o;
            if (!rck_o) begin
                hi_len <= '0;
            end else if (hi_len != RW'(RCK_CYC)) begin
                hi_len <= hi_len + 1'b1;
            end
        end
    end

    // R5: no read-clock pulse is shorter than RCK_CYC cycles
    a_r5_rck_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rck_prev && !rck_o) |-> (hi_len == RW'(RCK_CYC)));
endmodule

// File: rtl/fmc_bit_capture.sv
// On the cycle after a read-clock rising edge, captures the data level and raises a one-cycle strobe.
// Assumes the read clock is at least two cycles wide.
module fmc_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic rck_i,
    input  logic lvl_i,
    output logic valid_o,
    output logic bit_o
);
    logic rck_q;
    logic rise;

    // Purpose: delay the read clock for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rck_q <= 1'b0;
        end else begin
            rck_q <= rck_i;
        end
    end

    assign rise = rck_i & ~rck_q;

    // Purpose: the strobe and captured bit on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            bit_o   <= 1'b0;
        end else begin
            valid_o <= rise;
            if (rise) begin
                bit_o <= lvl_i;
            end
        end
    end

    // R6: the strobe lasts exactly one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/fm_read_conditioner.sv
// FM read data conditioner, top level.
// Chain: raw pulse -> synchronizer and edge detect -> gap timer and marker -> merged read-clock stretcher -> bit capture.
// Assumes a single sample clock, with all widths given in its cycles.
// Assumes TIMEOUT_CYC > RCK_CYC + 2.
module fm_read_conditioner #(
    parameter int unsigned TIMEOUT_CYC = fmc_pkg::FMC_TIMEOUT_DEF,
    parameter int unsigned MARK_CYC    = fmc_pkg::FMC_MARK_DEF,
    parameter int unsigned RCK_CYC     = fmc_pkg::FMC_RCK_DEF,
    parameter int unsigned SYNC_STAGES = fmc_pkg::FMC_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_pulse_i,
    output logic rdata_o,
    output logic rck_o,
    output logic bit_valid_o,
    output logic bit_o
);
    logic pulse_evt;
    logic mark;

    fmc_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (rd_pulse_i),
        .evt_o (pulse_evt)
    );

    fmc_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .MARK_CYC(MARK_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (pulse_evt),
        .lvl_o  (rdata_o),
        .mark_o (mark)
    );

    fmc_rck_stretch #(.RCK_CYC(RCK_CYC)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (pulse_evt),
        .mark_i (mark),
        .rck_o  (rck_o)
    );

    fmc_bit_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .rck_i   (rck_o),
        .lvl_i   (rdata_o),
        .valid_o (bit_valid_o),
        .bit_o   (bit_o)
    );

    // R4: a falling data level is followed by a read-clock pulse two cycles later
    a_r4_marker_drives_rck: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdata_o) |=> ##1 rck_o);
    // R6: every read-clock rising edge yields a strobe on the next cycle
    a_r6_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rck_o) |=> bit_valid_o);
endmodule

// File: tb/fm_read_conditioner_tb.sv
// Directed bench for the FM read conditioner.
// Each scenario task drives raw pulses at exact cycles and checks its own results.
module fm_read_conditioner_tb_top;
    localparam int T = 58;
    localparam int M = 1;
    localparam int R = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0;
    logic rdata, rck, dv, db;

    fm_read_conditioner #(.TIMEOUT_CYC(T), .MARK_CYC(M), .RCK_CYC(R), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_pulse_i  (rd),
        .rdata_o     (rdata),
        .rck_o       (rck),
        .bit_valid_o (dv),
        .bit_o       (db)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int got_c[64];
    int got_b[64];
    int got_n = 0;
    always @(negedge clk) begin
        if (dv && got_n < 64) begin
            got_c[got_n] = cyc;
            got_b[got_n] = int'(db);
            got_n = got_n + 1;
        end
    end

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int x);
        do @(negedge clk); while (cyc < x);
    endtask

    task automatic pulse_at(input int e, input int w);
        wait_cyc(e - 1);
        rd = 1'b1;
        repeat (w) @(negedge clk);
        rd = 1'b0;
    endtask

    int p_e[16];
    int p_w[16];
    int p_n;

    // Drives the pulse list, then compares the strobe log with the requirement model.
    task automatic run_pattern(input string tag, input int tail);
        int ex_c[64];
        int ex_b[64];
        int ex_n = 0;
        got_n = 0;
        for (int i = 0; i < p_n; i++) pulse_at(p_e[i], p_w[i]);
        wait_cyc(p_e[p_n-1] + tail);
        for (int i = 0; i < p_n; i++) begin
            ex_c[ex_n] = p_e[i] + 3; ex_b[ex_n] = 1; ex_n++;
            if (i == p_n - 1 || p_e[i+1] - p_e[i] >= T + R + 2) begin
                ex_c[ex_n] = p_e[i] + T + 5; ex_b[ex_n] = 0; ex_n++;
            end
        end
        chk(tag, "strobe count", got_n, ex_n);
        for (int i = 0; i < ex_n && i < got_n; i++) begin
            chk(tag, $sformatf("strobe %0d cycle", i), got_c[i], ex_c[i]);
            chk(tag, $sformatf("strobe %0d bit", i), got_b[i], ex_b[i]);
        end
    endtask

    task automatic test_reset();
        wait_cyc(3);
        chk("R1", "rdata in reset", int'(rdata), 0);
        chk("R1", "rck in reset", int'(rck), 0);
        chk("R1", "strobe in reset", int'(dv), 0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R1", "rdata after reset", int'(rdata), 0);
        chk("R1", "strobe after reset", int'(dv), 0);
    endtask

    task automatic test_reset_mid();
        int e;
        e = cyc + 4;
        got_n = 0;
        pulse_at(e, 1);
        wait_cyc(e + 1);
        rst_n = 1'b0;
        wait_cyc(e + 3);
        rst_n = 1'b1;
        wait_cyc(e + 4);
        chk("R1", "rdata after mid reset", int'(rdata), 0);
        chk("R1", "rck after mid reset", int'(rck), 0);
        wait_cyc(e + T + 20);
        chk("R1", "strobes after mid reset", got_n, 0);
    endtask

    task automatic test_single();
        int e;
        e = cyc + 4;
        got_n = 0;
        pulse_at(e, 1);
        wait_cyc(e + 1);
        chk("R2", "rdata before rise", int'(rdata), 0);
        chk("R5", "rck before rise", int'(rck), 0);
        wait_cyc(e + 2);
        chk("R2", "rdata at rise", int'(rdata), 1);
        chk("R5", "rck at rise", int'(rck), 1);
        wait_cyc(e + 3);
        chk("R6", "strobe of real pulse", int'(dv), 1);
        chk("R6", "bit of real pulse", int'(db), 1);
        wait_cyc(e + 4);
        chk("R6", "strobe one cycle", int'(dv), 0);
        wait_cyc(e + 1 + R);
        chk("R5", "rck last high cycle", int'(rck), 1);
        wait_cyc(e + 2 + R);
        chk("R5", "rck low after width", int'(rck), 0);
        wait_cyc(e + 1 + T);
        chk("R2", "rdata last high cycle", int'(rdata), 1);
        wait_cyc(e + 2 + T);
        chk("R2", "rdata low after timeout", int'(rdata), 0);
        wait_cyc(e + T + 5);
        chk("R4", "marker strobe", int'(dv), 1);
        chk("R4", "marker bit", int'(db), 0);
        wait_cyc(e + 4 * T);
        chk("R4", "one marker for long silence", got_n, 2);
    endtask

    task automatic test_ones();
        int b;
        b = cyc + 4;
        p_n = 8;
        for (int i = 0; i < 8; i++) begin p_e[i] = b + 40 * i; p_w[i] = 1; end
        run_pattern("R7 all ones (R3 no marker)", T + 20);
    endtask

    task automatic test_zeros();
        int b;
        b = cyc + 4;
        p_n = 4;
        for (int i = 0; i < 4; i++) begin p_e[i] = b + 80 * i; p_w[i] = 1; end
        run_pattern("R7 all zeros (R4 markers)", T + 20);
    endtask

    task automatic test_missing_clock();
        int b;
        b = cyc + 4;
        p_n = 5;
        p_e[0] = b;       p_e[1] = b + 40;  p_e[2] = b + 120;
        p_e[3] = b + 160; p_e[4] = b + 200;
        for (int i = 0; i < 5; i++) p_w[i] = 1;
        run_pattern("R7 missing clock", T + 20);
    endtask

    task automatic test_boundary();
        int b;
        b = cyc + 4;
        p_n = 3;
        p_e[0] = b; p_e[1] = b + T; p_e[2] = b + 2 * T + 1;
        for (int i = 0; i < 3; i++) p_w[i] = 1;
        run_pattern("R3/R8 timeout boundary", T + 20);
    endtask

    task automatic test_long_pulse();
        int b;
        b = cyc + 4;
        p_n = 2;
        p_e[0] = b;      p_w[0] = 3;
        p_e[1] = b + 40; p_w[1] = 5;
        run_pattern("R9 wide raw pulses", T + 20);
    endtask

    initial begin
        test_reset();
        test_single();
        test_ones();
        test_zeros();
        test_missing_clock();
        test_boundary();
        test_long_pulse();
        test_reset_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule